// File: doc/BRIEF.md
# Constant Off-Time Current Limiter with Short Blanking

This block guards one half-bridge output of a motor or solenoid driver. Each clock it compares a digital load-current code with two thresholds. The first is a limit threshold that depends on temperature. The second is a hard-short threshold, and which one applies depends on whether the high-side or the low-side switch is conducting.

When the current reaches the limit, the block raises `chop_o`. This holds the output off for a fixed number of cycles, after which the output switches back on by itself. Every time the output switches on, whether from an external activation strobe or from the end of an off period, a blanking window opens. While it is open, hard-short detection is masked so that switching spikes are not mistaken for a short.

A short seen outside blanking produces a one-cycle pulse for an external fault latch. As the junction gets hotter, the limit threshold falls linearly from its nominal value to a floor. A separate overtemperature flag with hysteresis is also driven from the temperature code. A lower bound on the chop period keeps the chopping frequency under a ceiling.

Top module: `ilim_chopper`

## Requirements
- R1: During reset and in the first cycle after it, `chop_o`, `short_o` and `ot_o` are all 0.
- R2: While the output is on and no period hold-off is pending, the block samples `cur_i` at each clock edge and compares it with the limit threshold. If `cur_i` is at least that threshold, `chop_o` is 1 from the next cycle for exactly OFF_CYC (default 20) cycles and then returns to 0.
- R3: A pulse on `act_i` while `chop_o` is 1 is ignored: the off period keeps its length of OFF_CYC cycles.
- R4: An `act_i` pulse sampled at clock edge a opens a blanking window. Hard-short detection is masked at edge a and at the BLANK_CYC (default 16) edges after it. Detection is live again at edge a+BLANK_CYC+1.
- R5: The current code has 0.1 A per LSB. When `side_hi_i`=1 the short threshold is 110; when `side_hi_i`=0 it is 80. If `cur_i` is at or above the selected threshold at an edge where the output is on and not blanked, `short_o` is 1 for the following cycle.
- R6: The edge at which an off period ends also opens a blanking window of BLANK_CYC edges, with the same masking as in R4.
- R7: The temperature code has 1 °C per LSB. The limit threshold is 65 at or below 160. Between 160 and 175 it is 65 − floor((t−160)·40/15). At or above 175 it is 25.
- R8: If the sampled temperature is above 175, `ot_o` is 1 from the next cycle. If it is at or below 160, `ot_o` is 0 from the next cycle. Between those values `ot_o` keeps its previous value.
- R9: Two successive rises of `chop_o` are at least MIN_PERIOD (default 50) cycles apart, even if the current stays above the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_i | input | 8 | Load-current code, 0.1 A per LSB |
| temp_i | input | 8 | Junction temperature code, 1 °C per LSB |
| side_hi_i | input | 1 | 1 selects the high-side short threshold, 0 the low-side one |
| act_i | input | 1 | Output-activation strobe |
| chop_o | output | 1 | Output held off by the current limiter |
| short_o | output | 1 | One-cycle hard-short event |
| ot_o | output | 1 | Overtemperature flag |

## Verification
Two functions can act on the same edge: a current above both thresholds makes the short detector and the limit chopper respond together. At the end of an off period, re-enabling the output overlaps with the blanking window and with the period hold-off.

The bench triggers a chop and then raises the current above the short threshold while the output is still off. Afterwards it checks three things cycle by cycle:
- `short_o` stays 0 up to the last blanked edge after re-enable.
- `short_o` fires on the next edge while `chop_o` is still held back by the period rule.
- `chop_o` rises again exactly at the period boundary.

Separate activation probes place a short current on the last blanked edge and on the first live edge, for each switch side.

// File: rtl/ilim_pkg.sv
package ilim_pkg;
  typedef enum logic {ST_ON = 1'b0, ST_OFF = 1'b1} seq_state_e;
endpackage

// File: rtl/ilim_foldback.sv
module ilim_foldback #(
  parameter int CUR_W    = 8,
  parameter int TEMP_W   = 8,
  parameter int ILIM_NOM = 65,
  parameter int ILIM_MIN = 25,
  parameter int FOLD_T0  = 160,
  parameter int FOLD_T1  = 175
) (
  input  logic [TEMP_W-1:0] temp_i,
  output logic [CUR_W-1:0]  thr_o
);
  localparam int SPAN  = FOLD_T1 - FOLD_T0;
  localparam int DROP  = ILIM_NOM - ILIM_MIN;
  localparam int FRAC  = 16;
  // reciprocal rounded up so the floor matches exact division on the span
  localparam int RECIP = ((1 << FRAC) + SPAN - 1) / SPAN;
  localparam int PW    = TEMP_W + CUR_W + FRAC + 2;

  localparam logic [PW-1:0] DROP_X  = PW'(DROP);
  localparam logic [PW-1:0] RECIP_X = PW'(RECIP);

  logic [PW-1:0] d_x;
  logic [PW-1:0] prod;

  always_comb begin
    d_x  = PW'(temp_i) - PW'(FOLD_T0);
    prod = d_x * DROP_X * RECIP_X;
    if (temp_i <= TEMP_W'(FOLD_T0))
      thr_o = CUR_W'(ILIM_NOM);
    else if (temp_i >= TEMP_W'(FOLD_T1))
      thr_o = CUR_W'(ILIM_MIN);
    else
      thr_o = CUR_W'(ILIM_NOM) - CUR_W'(prod >> FRAC);
  end
endmodule

// File: rtl/ilim_thermal.sv
module ilim_thermal #(
  parameter int TEMP_W  = 8,
  parameter int OT_TRIP = 175,
  parameter int OT_HYST = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              ot_o
);
  localparam int OT_CLR = OT_TRIP - OT_HYST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ot_o <= 1'b0;
    else if (temp_i > TEMP_W'(OT_TRIP))   ot_o <= 1'b1;
    else if (temp_i <= TEMP_W'(OT_CLR))   ot_o <= 1'b0;
  end
endmodule

// File: rtl/ilim_seq.sv
module ilim_seq
  import ilim_pkg::*;
#(
  parameter int CUR_W      = 8,
  parameter int OFF_CYC    = 20,
  parameter int BLANK_CYC  = 16,
  parameter int MIN_PERIOD = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CUR_W-1:0] cur_i,
  input  logic [CUR_W-1:0] lim_thr_i,
  input  logic [CUR_W-1:0] short_thr_i,
  input  logic             act_i,
  output logic             chop_o,
  output logic             short_o
);
  localparam int OFF_W = $clog2(OFF_CYC + 1);
  localparam int BLK_W = $clog2(BLANK_CYC + 1);
  localparam int PER_W = $clog2(MIN_PERIOD + 1);

  seq_state_e       state_q;
  logic [OFF_W-1:0] off_cnt_q;
  logic [BLK_W-1:0] blank_cnt_q;
  logic [PER_W-1:0] per_cnt_q;
  logic             short_q;
  logic             over_lim, over_short, live_det;

  assign over_lim   = cur_i >= lim_thr_i;
  assign over_short = cur_i >= short_thr_i;
  assign live_det   = !act_i && (blank_cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_ON;
      off_cnt_q   <= '0;
      blank_cnt_q <= '0;
      per_cnt_q   <= '0;
      short_q     <= 1'b0;
    end else begin
      short_q <= 1'b0;
      if (per_cnt_q != '0) per_cnt_q <= per_cnt_q - PER_W'(1);
      case (state_q)
        ST_ON: begin
          if (blank_cnt_q != '0) blank_cnt_q <= blank_cnt_q - BLK_W'(1);
          if (act_i) blank_cnt_q <= BLK_W'(BLANK_CYC);
          if (live_det && over_short) short_q <= 1'b1;
          if (over_lim && per_cnt_q == '0) begin
            state_q   <= ST_OFF;
            off_cnt_q <= OFF_W'(OFF_CYC - 1);
            per_cnt_q <= PER_W'(MIN_PERIOD - 1);
          end
        end
        ST_OFF: begin
          // activation strobes are dropped while held off
          if (off_cnt_q == '0) begin
            state_q     <= ST_ON;
            blank_cnt_q <= BLK_W'(BLANK_CYC);
          end else begin
            off_cnt_q <= off_cnt_q - OFF_W'(1);
          end
        end
        default: state_q <= ST_ON;
      endcase
    end
  end

  assign chop_o  = (state_q == ST_OFF);
  assign short_o = short_q;
endmodule

// File: rtl/ilim_chopper.sv
module ilim_chopper #(
  parameter int CUR_W      = 8,
  parameter int TEMP_W     = 8,
  parameter int ILIM_NOM   = 65,
  parameter int ILIM_MIN   = 25,
  parameter int SC_HI      = 110,
  parameter int SC_LO      = 80,
  parameter int FOLD_T0    = 160,
  parameter int FOLD_T1    = 175,
  parameter int OT_HYST    = 15,
  parameter int OFF_CYC    = 20,
  parameter int BLANK_CYC  = 16,
  parameter int MIN_PERIOD = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CUR_W-1:0]  cur_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              side_hi_i,
  input  logic              act_i,
  output logic              chop_o,
  output logic              short_o,
  output logic              ot_o
);
  logic [CUR_W-1:0] lim_thr;
  logic [CUR_W-1:0] short_thr;

  assign short_thr = side_hi_i ? CUR_W'(SC_HI) : CUR_W'(SC_LO);

  ilim_foldback #(
    .CUR_W(CUR_W), .TEMP_W(TEMP_W), .ILIM_NOM(ILIM_NOM), .ILIM_MIN(ILIM_MIN),
    .FOLD_T0(FOLD_T0), .FOLD_T1(FOLD_T1)
  ) fold_i (
    .temp_i(temp_i),
    .thr_o (lim_thr)
  );

  ilim_thermal #(
    .TEMP_W(TEMP_W), .OT_TRIP(FOLD_T1), .OT_HYST(OT_HYST)
  ) therm_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .temp_i(temp_i),
    .ot_o  (ot_o)
  );

  ilim_seq #(
    .CUR_W(CUR_W), .OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC), .MIN_PERIOD(MIN_PERIOD)
  ) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_i      (cur_i),
    .lim_thr_i  (lim_thr),
    .short_thr_i(short_thr),
    .act_i      (act_i),
    .chop_o     (chop_o),
    .short_o    (short_o)
  );
endmodule

// File: rtl/ilim_chopper_chk.sv
module ilim_chopper_chk #(
  parameter int TEMP_W     = 8,
  parameter int FOLD_T1    = 175,
  parameter int OT_HYST    = 15,
  parameter int OFF_CYC    = 20,
  parameter int BLANK_CYC  = 16,
  parameter int MIN_PERIOD = 50
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [TEMP_W-1:0] temp_i,
  input logic              act_i,
  input logic              chop_o,
  input logic              short_o,
  input logic              ot_o
);
  localparam int LEN_W = $clog2(OFF_CYC + 2);
  localparam int AGE_W = $clog2(BLANK_CYC + 2);
  localparam int GAP_W = $clog2(MIN_PERIOD + 1);

  logic [LEN_W-1:0] len_q;
  logic [AGE_W-1:0] age_q;
  logic [GAP_W-1:0] gap_q;
  logic             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      age_q  <= AGE_W'(BLANK_CYC + 1);
      gap_q  <= GAP_W'(MIN_PERIOD);
      prev_q <= 1'b0;
    end else begin
      prev_q <= chop_o;
      if (!chop_o) len_q <= '0;
      else if (len_q != LEN_W'(OFF_CYC + 1)) len_q <= len_q + LEN_W'(1);
      if (act_i || chop_o) age_q <= '0;
      else if (age_q != AGE_W'(BLANK_CYC + 1)) age_q <= age_q + AGE_W'(1);
      if (chop_o && !prev_q) gap_q <= GAP_W'(1);
      else if (gap_q != GAP_W'(MIN_PERIOD)) gap_q <= gap_q + GAP_W'(1);
    end
  end

  assert_chop_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chop_o |-> len_q < LEN_W'(OFF_CYC));
  assert_chop_exact_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_q && !chop_o) |-> len_q == LEN_W'(OFF_CYC));
  assert_blank_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |-> age_q >= AGE_W'(BLANK_CYC + 1));
  assert_act_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> !short_o);
  assert_no_short_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chop_o |=> !short_o);
  assert_ot_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i > TEMP_W'(FOLD_T1)) |=> ot_o);
  assert_ot_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i <= TEMP_W'(FOLD_T1 - OT_HYST)) |=> !ot_o);
  assert_ot_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i > TEMP_W'(FOLD_T1 - OT_HYST) && temp_i <= TEMP_W'(FOLD_T1)) |=> (ot_o == $past(ot_o)));
  assert_min_period_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chop_o && !prev_q) |-> gap_q >= GAP_W'(MIN_PERIOD));
endmodule

bind ilim_chopper ilim_chopper_chk #(
  .TEMP_W(TEMP_W), .FOLD_T1(FOLD_T1), .OT_HYST(OT_HYST),
  .OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC), .MIN_PERIOD(MIN_PERIOD)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .temp_i (temp_i),
  .act_i  (act_i),
  .chop_o (chop_o),
  .short_o(short_o),
  .ot_o   (ot_o)
);

// File: tb/ilim_chopper_tb_top.sv
module ilim_chopper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_CYC    = 20;
  localparam int MIN_PERIOD = 50;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] cur_i;
  logic [7:0] temp_i;
  logic       side_hi_i;
  logic       act_i;
  logic       chop_o, short_o, ot_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  ilim_chopper dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_i(cur_i), .temp_i(temp_i),
    .side_hi_i(side_hi_i), .act_i(act_i),
    .chop_o(chop_o), .short_o(short_o), .ot_o(ot_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    cur_i = 8'd0;
    act_i = 1'b0;
    repeat (n) tick();
  endtask

  function automatic int exp_thr(input int t);
    if (t <= 160) return 65;
    if (t >= 175) return 25;
    return 65 - ((t - 160) * 40) / 15;
  endfunction

  task automatic t_reset();
    rst_ni = 1'b0; cur_i = 8'd0; temp_i = 8'd25; side_hi_i = 1'b0; act_i = 1'b0;
    repeat (3) tick();
    chk("R1 chop in reset", chop_o, 0);
    chk("R1 short in reset", short_o, 0);
    chk("R1 ot in reset", ot_o, 0);
    rst_ni = 1'b1;
    tick();
    chk("R1 chop after reset", chop_o, 0);
    chk("R1 ot after reset", ot_o, 0);
  endtask

  // measure off-time length, optionally pulsing act_i mid-way
  task automatic t_chop_len(input bit act_mid, input string req);
    int n;
    idle(60);
    cur_i = 8'd70;
    tick();
    cur_i = 8'd0;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (!chop_o) break;
      n++;
      act_i = (act_mid && i == 4);
      tick();
    end
    act_i = 1'b0;
    chk(req, n, OFF_CYC);
  endtask

  // act at edge a, short-level current applied at edge a+k
  task automatic t_short(input bit side, input int cur, input int k, input int exp, input string req);
    idle(60);
    side_hi_i = side;
    act_i = 1'b1;
    if (k == 0) cur_i = 8'(cur);
    tick();
    act_i = 1'b0;
    if (k > 0) begin
      repeat (k - 1) tick();
      cur_i = 8'(cur);
      tick();
    end
    chk(req, short_o, exp);
    idle(60);
  endtask

  // R6, R9: re-enable blanking and minimum chop period under sustained overcurrent
  task automatic t_reentry();
    idle(60);
    side_hi_i = 1'b0;
    cur_i = 8'd70;
    tick();
    chk("R2 chop rises", chop_o, 1);
    cur_i = 8'd85;
    for (int j = 1; j <= MIN_PERIOD; j++) begin
      tick();
      if (j == 36) chk("R6 short masked last blank edge", short_o, 0);
      if (j == 37) chk("R6 short after reentry blank", short_o, 1);
      if (j == 49) chk("R9 no chop before period", chop_o, 0);
      if (j == 50) chk("R9 chop at period boundary", chop_o, 1);
    end
    idle(60);
  endtask

  task automatic t_fold(input int t);
    int thr;
    temp_i = 8'(t);
    idle(60);
    thr = exp_thr(t);
    cur_i = 8'(thr - 1);
    tick();
    chk($sformatf("R7 no chop below thr t=%0d", t), chop_o, 0);
    idle(3);
    cur_i = 8'(thr);
    tick();
    chk($sformatf("R7 chop at thr t=%0d", t), chop_o, 1);
    idle(60);
  endtask

  task automatic t_ot_step(input int t, input int exp);
    temp_i = 8'(t);
    tick();
    chk($sformatf("R8 ot t=%0d", t), ot_o, exp);
  endtask

  initial begin
    t_reset();
    t_chop_len(1'b0, "R2 off length");
    t_chop_len(1'b1, "R3 act ignored during off");
    t_short(1'b0, 85, 0, 0, "R4 short masked at act edge");
    t_short(1'b0, 85, 16, 0, "R4 short masked last blank edge");
    t_short(1'b0, 85, 17, 1, "R4 short live after blank");
    t_short(1'b0, 79, 30, 0, "R5 low side below thr");
    t_short(1'b0, 80, 30, 1, "R5 low side at thr");
    t_short(1'b1, 109, 30, 0, "R5 high side below thr");
    t_short(1'b1, 110, 30, 1, "R5 high side at thr");
    t_reentry();
    t_fold(100);
    t_fold(160);
    t_fold(161);
    t_fold(168);
    t_fold(174);
    t_fold(175);
    t_fold(190);
    t_ot_step(25, 0);
    t_ot_step(175, 0);
    t_ot_step(176, 1);
    t_ot_step(168, 1);
    t_ot_step(161, 1);
    t_ot_step(160, 0);
    t_ot_step(170, 0);
    t_ot_step(200, 1);
    t_ot_step(25, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule